// File: doc/BRIEF.md
# Infrared SIR Frame Transmit Escaper

This block turns a stream of frame payload bytes into the byte sequence that an infrared serial link sends. It opens each frame with a start flag. It then forwards the payload and appends a two-byte frame check. A closing flag ends the frame. Three byte values are reserved for framing: 0xC0 is the start flag, 0xC1 is the end flag and 0x7D is the escape. When one of these values turns up in the payload or in the check bytes, the block inserts an escape byte in front of it and sends the byte with bit 5 inverted.

Payload enters on a valid/ready byte interface that carries a last-byte marker. The escaped stream leaves on a second valid/ready interface, through a one-entry output register. Upstream logic can raise an abort request while a frame is in progress. The block then ends the frame with the two-byte abort pair and sends neither a check field nor an end flag.

Top module: `irda_sir_tx_escaper`

## Requirements
- R1: During reset and right after it, out_valid and in_ready are both low.
- R2: When the first byte of a frame is offered on the input, the block first emits 0xC0 on the output, before any byte of that frame.
- R3: Payload bytes that are not 0xC0, 0xC1 or 0x7D are emitted unchanged and in input order.
- R4: A payload byte equal to 0xC0, 0xC1 or 0x7D is emitted as 0x7D followed by the byte XOR 0x20.
- R5: The inserted 0x7D takes one extra output beat. in_ready stays low for that beat, so a reserved input byte is accepted only in the cycle in which its escape byte leaves the output register.
- R6: After the byte marked last, the block emits the ones-complement of a 16-bit CRC, low byte first. The CRC uses polynomial x^16+x^12+x^5+1 in reflected bit order (0x8408), is shifted least significant bit first, starts at 0xFFFF, and covers the original payload bytes.
- R7: A check byte equal to 0xC0, 0xC1 or 0x7D is escaped in the same way as a payload byte.
- R8: The frame ends with 0xC1 after the two check bytes.
- R9: An abort request raised while a frame is in progress makes the block emit 0x7D then 0xC1 at the next byte boundary. The frame then ends with no check bytes and no end flag, and the pending request clears itself.
- R10: An abort request raised while no frame is in progress is ignored: no output appears, and the next frame is normal.
- R11: After an abort, the CRC of the next frame starts again from 0xFFFF.
- R12: While out_valid is high and out_ready is low, out_valid and out_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input payload byte valid |
| in_ready | output | 1 | Input payload byte accepted this cycle |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte of a frame |
| abort_req | input | 1 | Request to abort the frame in progress |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Framed and escaped byte |

## Verification
A corrupted escape flag would show up at once on the output. A reserved byte would leave without its 0x7D prefix, or an extra 0x7D would appear, within the same frame, and the output length and contents would differ from the model. A CRC register that is not preset would change both check bytes of the next complete frame. This matters most for the frame that follows an abort. A stuck abort flag would cut short the next frame at its first byte boundary. A stalled output byte that changes would show up in the cycle after the stall.

// File: rtl/irda_sir_tx_escaper.sv
module irda_sir_tx_escaper #(
  parameter logic [15:0] CRC_PRESET = 16'hFFFF,
  parameter logic [15:0] CRC_POLY_REV = 16'h8408
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       abort_req,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam logic [7:0] FLAG_OPEN  = 8'hC0;
  localparam logic [7:0] FLAG_CLOSE = 8'hC1;
  localparam logic [7:0] ESC_BYTE   = 8'h7D;
  localparam logic [7:0] ESC_FLIP   = 8'h20;

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_CHK_LO, S_CHK_HI, S_END, S_ABT} state_t;

  state_t      state;
  logic        esc_q, abort_q, out_v_q;
  logic [15:0] crc_q;
  logic [7:0]  out_q, src, gen_d;
  logic        src_v, gen_v;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REV;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_comb begin
    src   = in_data;
    src_v = 1'b0;
    case (state)
      S_DATA:   src_v = in_valid;
      S_CHK_LO: begin src = ~crc_q[7:0];  src_v = 1'b1; end
      S_CHK_HI: begin src = ~crc_q[15:8]; src_v = 1'b1; end
      default:  ;
    endcase
  end

  wire in_body  = (state == S_DATA) || (state == S_CHK_LO) || (state == S_CHK_HI);
  wire resv     = (src == FLAG_OPEN) || (src == FLAG_CLOSE) || (src == ESC_BYTE);
  wire abort_go = in_body && abort_q && !esc_q;
  wire esc_go   = in_body && !abort_go && src_v && resv && !esc_q;
  wire send_src = in_body && !abort_go && src_v && !esc_go;
  wire load     = !out_v_q || out_ready;
  wire step     = load && gen_v;

  always_comb begin
    gen_v = 1'b0;
    gen_d = ESC_BYTE;
    case (state)
      S_IDLE:       begin gen_v = in_valid; gen_d = FLAG_OPEN; end
      S_END, S_ABT: begin gen_v = 1'b1;     gen_d = FLAG_CLOSE; end
      default: begin
        gen_v = abort_go || esc_go || send_src;
        if (send_src) gen_d = esc_q ? (src ^ ESC_FLIP) : src;
      end
    endcase
  end

  assign in_ready  = load && (state == S_DATA) && !(abort_q && !esc_q) && !(resv && !esc_q);
  assign out_valid = out_v_q;
  assign out_data  = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      esc_q   <= 1'b0;
      abort_q <= 1'b0;
      crc_q   <= CRC_PRESET;
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else begin
      if (load) out_v_q <= gen_v;
      if (step) out_q <= gen_d;

      if (step && (state == S_END || state == S_ABT)) abort_q <= 1'b0;
      else if (abort_req && in_body)                   abort_q <= 1'b1;

      if (step && esc_go)        esc_q <= 1'b1;
      else if (step && send_src) esc_q <= 1'b0;

      if (step && state == S_DATA && send_src)          crc_q <= crc_step(crc_q, in_data);
      else if (step && (state == S_END || state == S_ABT)) crc_q <= CRC_PRESET;

      if (step) begin
        case (state)
          S_IDLE: state <= S_DATA;
          S_DATA, S_CHK_LO, S_CHK_HI: begin
            if (abort_go) state <= S_ABT;
            else if (send_src) begin
              if (state == S_DATA)        state <= in_last ? S_CHK_LO : S_DATA;
              else if (state == S_CHK_LO) state <= S_CHK_HI;
              else                        state <= S_END;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_escape_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && in_valid && resv && !esc_q) |-> !in_ready);

  p_accept_needs_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid || out_ready));

  p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ABT && load) |=> !abort_q);

  p_idle_no_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !abort_q);

  p_crc_preset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (crc_q == CRC_PRESET));
endmodule

// File: tb/test_irda_sir_tx_escaper.sv
module test_irda_sir_tx_escaper;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, in_valid, in_last, abort_req, out_ready, bp_on;
  logic [7:0] in_data;
  wire        in_ready, out_valid;
  wire  [7:0] out_data;

  int checks = 0, fails = 0, hold_err = 0, r5_err = 0, r5_seen = 0;
  logic [7:0] outq[$];
  logic       pv = 1'b0, pr = 1'b0;
  logic [7:0] pd = '0;

  irda_sir_tx_escaper i_irda_sir_tx_escaper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .abort_req(abort_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  function automatic bit is_res(input logic [7:0] b);
    return (b == 8'hC0) || (b == 8'hC1) || (b == 8'h7D);
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic void build(input logic [7:0] d[$], input bit ab, output logic [7:0] e[$]);
    logic [15:0] c;
    logic [7:0]  k[2];
    e = {};
    c = 16'hFFFF;
    e.push_back(8'hC0);
    foreach (d[i]) begin
      if (is_res(d[i])) begin e.push_back(8'h7D); e.push_back(d[i] ^ 8'h20); end
      else e.push_back(d[i]);
      c = ref_crc(c, d[i]);
    end
    if (ab) begin e.push_back(8'h7D); e.push_back(8'hC1); return; end
    c = ~c;
    k[0] = c[7:0];
    k[1] = c[15:8];
    for (int j = 0; j < 2; j++) begin
      if (is_res(k[j])) begin e.push_back(8'h7D); e.push_back(k[j] ^ 8'h20); end
      else e.push_back(k[j]);
    end
    e.push_back(8'hC1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (pv && !pr && !(out_valid && out_data == pd)) hold_err++;
        if (out_valid && out_ready) outq.push_back(out_data);
      end
      pv = out_valid; pr = out_ready; pd = out_data;
    end
  end

  task automatic send_frame(input logic [7:0] d[$], input bit ab, input bit gaps);
    bit acc;
    foreach (d[i]) begin
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
      in_valid = 1'b1;
      in_data  = d[i];
      in_last  = !ab && (i == d.size() - 1);
      forever begin
        #2;
        acc = in_valid && in_ready;
        if (acc && is_res(in_data)) begin
          r5_seen++;
          if (!(out_valid && out_data == 8'h7D && out_ready)) r5_err++;
        end
        @(negedge clk);
        if (acc) break;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
    if (ab) begin
      repeat (2) @(negedge clk);
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
    end
  endtask

  task automatic compare(input logic [7:0] e[$], input string tag);
    int t = 0;
    int bad = -1;
    while (outq.size() < e.size() && t < 3000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    check(outq.size() > 0 && outq[0] == 8'hC0, "R2 open flag", outq.size() > 0 ? outq[0] : -1, 8'hC0);
    if (outq.size() == e.size())
      foreach (e[i]) if (bad < 0 && outq[i] != e[i]) bad = i;
    if (outq.size() != e.size()) check(1'b0, {tag, " length"}, outq.size(), e.size());
    else if (bad >= 0)           check(1'b0, {tag, " byte"}, outq[bad], e[bad]);
    else                         check(1'b1, tag, 0, 0);
    outq.delete();
  endtask

  task automatic run(input logic [7:0] d[$], input bit ab, input bit gaps, input string tag);
    logic [7:0] e[$];
    build(d, ab, e);
    send_frame(d, ab, gaps);
    compare(e, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d[$];
    logic [7:0] e[$];
    logic [15:0] c;
    bit found;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b1; in_data = 8'h55; in_last = 1'b0; abort_req = 1'b0; bp_on = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(!out_valid, "R1 out_valid in reset", out_valid, 0);
    check(!in_ready, "R1 in_ready in reset", in_ready, 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!out_valid && !in_ready, "R1 after reset", {out_valid, in_ready}, 0);
    @(negedge clk);

    run('{8'h11, 8'h22, 8'h33}, 1'b0, 1'b0, "R3 R6 R8 plain frame");
    run('{8'hC0, 8'hC1, 8'h7D, 8'h00}, 1'b0, 1'b0, "R4 reserved payload");
    check(r5_err == 0 && r5_seen == 3, "R5 escape stall", r5_err, 0);

    found = 1'b0;
    d = {};
    for (int a = 0; a < 256 && !found; a++)
      for (int b = 0; b < 256 && !found; b++) begin
        c = ~ref_crc(ref_crc(16'hFFFF, a[7:0]), b[7:0]);
        if (!is_res(a[7:0]) && !is_res(b[7:0]) && (is_res(c[7:0]) || is_res(c[15:8]))) begin
          found = 1'b1;
          d = '{a[7:0], b[7:0]};
        end
      end
    run(d, 1'b0, 1'b0, "R7 escaped check byte");

    run('{8'h44, 8'h7D, 8'h12}, 1'b1, 1'b0, "R9 abort");
    run('{8'h5A, 8'hA5}, 1'b0, 1'b0, "R11 frame after abort");

    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    repeat (5) @(negedge clk);
    check(outq.size() == 0 && !out_valid, "R10 idle abort output", outq.size(), 0);
    run('{8'h01, 8'h02}, 1'b0, 1'b0, "R10 frame after idle abort");

    bp_on = 1'b1;
    for (int f = 0; f < 24; f++) begin
      int n;
      bit ab;
      d = {};
      n = $urandom_range(1, 12);
      for (int i = 0; i < n; i++)
        d.push_back(($urandom_range(0, 3) == 0) ? ((i % 3 == 0) ? 8'hC0 : (i % 3 == 1) ? 8'hC1 : 8'h7D)
                                                  : 8'($urandom_range(0, 255)));
      ab = ($urandom_range(0, 4) == 0);
      run(d, ab, 1'b1, ab ? "R9 R11 random abort" : "R3 R4 R6 R7 R8 random frame");
    end
    check(r5_err == 0, "R5 random escape stall", r5_err, 0);
    check(hold_err == 0, "R12 stalled output held", hold_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule